// File: doc/BRIEF.md
# Twisted-Ring Divider with One-Hot Decode

This block divides a clock by twice its stage count. The count is held in a twisted-ring shift register. On each advance, every stage takes the value of the stage before it, and the first stage takes the complement of the last stage. The ring therefore fills with ones and then empties, and returns to all zeros after `2*STAGES` advances. Each ring state is decoded into one line of a one-hot output bus. A carry line gives a square wave at the divided rate, which can be used to chain further dividers.

Two sizes are supported. Four stages give eight decoded lines and divide by eight. Five stages give ten decoded lines and divide by ten.

A synchronous active-high reset returns the ring to its zero count. A level-sensitive hold input freezes the count while it is high. The second stage has a corrected feedback term, so any pattern that is not a legal ring state rejoins the legal sequence after a bounded number of advances. The decoded lines and the carry are registered, and they change only on a rising clock edge.

Top module: `johnson_divider`

## Requirements
- R1: `STAGES` may be 4 or 5, `count_onehot` is `2*STAGES` bits wide, and after `2*STAGES` advances from count 0 the count is 0 again (divide by `2*STAGES`).
- R2: A rising edge with `rst` high clears the ring, so that `count_onehot` equals 1 (bit 0 set) and `carry_out` is 1. This happens whatever the value of `hold`.
- R3: A rising edge with `rst` low and `hold` low moves the set bit of `count_onehot` from bit k to bit k+1, and from bit `2*STAGES-1` back to bit 0.
- R4: A rising edge with `rst` low and `hold` high leaves `count_onehot` and `carry_out` unchanged.
- R5: Whenever the ring holds a legal state, exactly one bit of `count_onehot` is set.
- R6: `carry_out` is 1 while the count is in 0 .. `STAGES-1` and 0 while the count is in `STAGES` .. `2*STAGES-1`. It is a 50% duty square wave at clock / `2*STAGES`.
- R7: From any stage pattern, the ring reaches a legal state within `4*STAGES` advances. From then on it follows the R3 order with R5 holding.
- R8: The outputs are registered. They take the decode of the ring value loaded at the same rising edge, and they do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the count advances on the rising edge |
| rst | input | 1 | Synchronous active-high clear to count 0 |
| hold | input | 1 | Active-high freeze of the count |
| count_onehot | output | 2*STAGES | Registered one-hot decode of the count |
| carry_out | output | 1 | Registered carry, high for the first half of the cycle |

## Verification
The bench applies reset with hold also high. A design that gave hold priority over reset would keep its old count, and the bench would see it. It steps through the wrap from the last count back to count 0. Here a feedback error shows up as a double-hot output or a count that does not return to 0. It also checks the carry at the half-cycle boundary, where a carry taken from the wrong stage is high or low for the wrong counts. Finally, the bench loads illegal stage patterns into the ring. It then checks that the output becomes one-hot within the bound and rotates correctly after that. A ring without the correction term would stay double-hot forever.

// File: rtl/jdiv_pkg.sv
package jdiv_pkg;
  localparam int MAX_STAGES = 8;

  // A legal twisted-ring state has at most one boundary between neighbour stages.
  function automatic logic ring_legal(input logic [MAX_STAGES-1:0] s, input int n);
    int edges;
    edges = 0;
    for (int i = 0; i < MAX_STAGES - 1; i++) begin
      if (i < n - 1 && s[i] != s[i+1]) edges++;
    end
    return edges <= 1;
  endfunction
endpackage

// File: rtl/jdiv_next.sv
module jdiv_next #(
  parameter int STAGES = 5
) (
  input  logic [STAGES-1:0] ring_q,
  output logic [STAGES-1:0] ring_adv
);
  // Stage 0 takes the complement of the last stage.
  assign ring_adv[0] = ~ring_q[STAGES-1];

  // Stage 1 has the correction term: an isolated one in stage 0 is not
  // copied when the last stage is high, which breaks illegal loops.
  assign ring_adv[1] = ring_q[0] & (ring_q[1] | ~ring_q[STAGES-1]);

  genvar i;
  generate
    for (i = 2; i < STAGES; i++) begin : g_shift
      assign ring_adv[i] = ring_q[i-1];
    end
  endgenerate
endmodule

// File: rtl/jdiv_decode.sv
module jdiv_decode #(
  parameter int STAGES = 5,
  localparam int DEC_W = 2 * STAGES
) (
  input  logic [STAGES-1:0] ring,
  output logic [DEC_W-1:0]  onehot,
  output logic              carry
);
  // Count 0: both end stages clear. Count STAGES: both end stages set.
  assign onehot[0]      = ~ring[0] & ~ring[STAGES-1];
  assign onehot[STAGES] =  ring[0] &  ring[STAGES-1];

  genvar k;
  generate
    for (k = 1; k < STAGES; k++) begin : g_window
      // Filling phase: a 1-to-0 boundary after stage k-1.
      assign onehot[k]          =  ring[k-1] & ~ring[k];
      // Emptying phase: a 0-to-1 boundary after stage k-1.
      assign onehot[STAGES + k] = ~ring[k-1] &  ring[k];
    end
  endgenerate

  // The last stage is clear for counts 0 .. STAGES-1 only.
  assign carry = ~ring[STAGES-1];
endmodule

// File: rtl/johnson_divider.sv
module johnson_divider #(
  parameter int STAGES = 5,
  localparam int DEC_W = 2 * STAGES,
  localparam int RECOVER_MAX = 4 * STAGES,
  localparam int RC_W = $clog2(RECOVER_MAX + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  output logic [DEC_W-1:0] count_onehot,
  output logic             carry_out
);
  import jdiv_pkg::*;

  generate
    if (STAGES < 4 || STAGES > 5) begin : g_bad_stages
      $error("johnson_divider: STAGES must be 4 or 5");
    end
  endgenerate

  logic [STAGES-1:0] ring_q;
  logic [STAGES-1:0] ring_adv;
  logic [STAGES-1:0] ring_d;
  logic [DEC_W-1:0]  dec_d;
  logic              carry_d;

  jdiv_next #(.STAGES(STAGES)) u_next (
    .ring_q  (ring_q),
    .ring_adv(ring_adv)
  );

  always_comb begin
    if (rst)       ring_d = '0;
    else if (hold) ring_d = ring_q;
    else           ring_d = ring_adv;
  end

  // Decode the value being loaded, so the registered outputs line up with the ring.
  jdiv_decode #(.STAGES(STAGES)) u_dec (
    .ring  (ring_d),
    .onehot(dec_d),
    .carry (carry_d)
  );

  always_ff @(posedge clk) begin
    ring_q       <= ring_d;
    count_onehot <= dec_d;
    carry_out    <= carry_d;
  end

  // Checker state: advancing cycles spent in an illegal ring state.
  logic            q_legal;
  logic [RC_W-1:0] bad_run;
  assign q_legal = ring_legal(MAX_STAGES'(ring_q), STAGES);

  always_ff @(posedge clk) begin
    if (rst || q_legal) bad_run <= '0;
    else if (!hold && bad_run <= RC_W'(RECOVER_MAX)) bad_run <= bad_run + 1'b1;
  end

  assert_reset_zero_R2: assert property (@(posedge clk)
    rst |=> (count_onehot == DEC_W'(1)) && carry_out);

  assert_hold_freeze_R4: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(count_onehot) && $stable(carry_out));

  assert_step_order_R3: assert property (@(posedge clk) disable iff (rst)
    (!hold && q_legal) |=>
      count_onehot == {$past(count_onehot[DEC_W-2:0]), $past(count_onehot[DEC_W-1])});

  assert_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    q_legal |-> $onehot(count_onehot));

  assert_carry_half_R6: assert property (@(posedge clk) disable iff (rst)
    q_legal |-> carry_out == (|count_onehot[STAGES-1:0]));

  assert_recover_bound_R7: assert property (@(posedge clk) disable iff (rst)
    bad_run <= RC_W'(RECOVER_MAX));
endmodule

// File: tb/sim_johnson_divider.sv
module sim_johnson_divider;
  localparam int STAGES = 5;
  localparam int DEC_W  = 2 * STAGES;
  localparam int NCNT   = DEC_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hold = 1'b0;
  logic [DEC_W-1:0] count_onehot;
  logic carry_out;

  int n_chk = 0;
  int n_bad = 0;
  int model = 0;

  always #5 clk = ~clk;

  johnson_divider #(.STAGES(STAGES)) u0 (
    .clk(clk), .rst(rst), .hold(hold),
    .count_onehot(count_onehot), .carry_out(carry_out)
  );

  // Stimulus vectors: {rst, hold}
  localparam int NVEC = 24;
  localparam logic [1:0] VEC [NVEC] = '{
    2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b01,
    2'b01, 2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 2'b00,
    2'b00, 2'b00, 2'b10, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00
  };

  task automatic check(input string req, input logic [DEC_W-1:0] exp_o, input logic exp_c);
    n_chk++;
    if (count_onehot !== exp_o || carry_out !== exp_c) begin
      n_bad++;
      $display("FAIL %s: onehot=%b carry=%b expected onehot=%b carry=%b",
               req, count_onehot, carry_out, exp_o, exp_c);
    end
  endtask

  // Drive at the falling edge, sample 1 ns after the rising edge.
  task automatic step(input logic r, input logic h);
    @(negedge clk);
    rst = r; hold = h;
    @(posedge clk);
    #1;
    if (r) model = 0;
    else if (!h) model = (model + 1) % NCNT;
  endtask

  function automatic logic [DEC_W-1:0] exp_o();
    return DEC_W'(1) << model;
  endfunction

  function automatic logic exp_c();
    return model < STAGES;
  endfunction

  task automatic recover(input logic [STAGES-1:0] pat);
    int idx;
    @(negedge clk);
    rst = 1'b0; hold = 1'b0;
    force u0.ring_q = pat;
    #1 release u0.ring_q;
    for (int i = 0; i < 4 * STAGES; i++) step(1'b0, 1'b0);
    n_chk++;
    if (!$onehot(count_onehot)) begin
      n_bad++;
      $display("FAIL R7: onehot=%b after %0d advances, expected a single set bit",
               count_onehot, 4 * STAGES);
    end
    idx = 0;
    for (int b = 0; b < DEC_W; b++) if (count_onehot[b]) idx = b;
    model = idx;
    for (int i = 0; i < NCNT; i++) begin
      step(1'b0, 1'b0);
      check("R7 R3 after recovery", exp_o(), exp_c());
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    check("R2 reset state", DEC_W'(1), 1'b1);

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      step(VEC[v][1], VEC[v][0]);
      if (VEC[v][1])      check("R2 reset", exp_o(), exp_c());
      else if (VEC[v][0]) check("R4 hold", exp_o(), exp_c());
      else                check("R3 R6 advance", exp_o(), exp_c());
    end

    // R8: no change between edges
    @(negedge clk);
    check("R8 stable between edges", exp_o(), exp_c());

    // Full cycles from zero: wrap and carry boundary
    step(1'b1, 1'b0);
    for (int i = 0; i < 2 * NCNT; i++) begin
      step(1'b0, 1'b0);
      if (model == 0) check("R1 wrap to zero", exp_o(), exp_c());
      else if (model == STAGES || model == STAGES - 1) check("R6 carry edge", exp_o(), exp_c());
      else check("R5 R3 cycle", exp_o(), exp_c());
    end

    // Reset mid-count while hold is high
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
    step(1'b1, 1'b1);
    check("R2 reset beats hold", DEC_W'(1), 1'b1);
    step(1'b0, 1'b1);
    check("R4 hold at zero", DEC_W'(1), 1'b1);

    // Illegal states
    recover(STAGES'(4));
    recover(STAGES'(10'b0101010101));
    recover(STAGES'(10'b1101101101));
    recover(STAGES'(10'b1001010010));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule